// File: doc/BRIEF.md
# Display Controller Host Register Bank

This block is the host-facing register file of a character display controller. A host selects one of eight byte-wide locations with a 3-bit index. It reaches them only while the chip select is high and the active-low address strobe is low. Location 0 accepts command bytes on write and returns a status byte on read. Locations 1 to 7 hold command arguments: three data bytes, an auxiliary pointer pair and a main pointer pair.

A command written while the block is idle starts a run of fixed length. The busy flag stays up for the whole run. When the run ends, the block updates the pointers and the status flags. If the command asks for it, the selected pointer's column advances by one, and the status flags record whether that column sat on the last position of a row. The indirect command type moves a byte between data location 1 and one of eight internal resource registers. Memory access, character drawing and video timing are outside this block. All ports are plain control and status pins and carry no stream traffic, so the block has no valid/ready handshake and no back-pressure.

Top module: `dpu_host_regs`

## Requirements
- R1: A location is accessed only when `cs` is 1 and `as_n` is 0. Writes (`we`=1) take effect at the rising clock edge in that condition. `rdata` is 0 whenever the block is not being read.
- R2: Locations 1 to 3 are data bytes. Location 4 holds the auxiliary row and location 5 bits 5:0 hold the auxiliary column. Location 6 holds the main row and location 7 bits 5:0 hold the main column. All seven reset to 0 and can be read and written at any time, including while busy.
- R3: Command byte fields: bits 7:4 give the type, and 4'b1000 means indirect. Bit 3 is the direction. For other types, bit 2 selects the pointer (1 auxiliary, 0 main) and bit 0 requests a post-increment.
- R4: A write to location 0 while idle starts a command. Status bit 7 reads 1 from the next cycle for LAT clock edges (default 4), then reads 0.
- R5: A write to location 0 while status bit 7 is 1 is ignored.
- R6: Status bits 6 to 3 are cleared when a command starts.
- R7: At completion, status bit 5 is set if the main column was 39 and status bit 4 is set if the auxiliary column was 39. Both are judged before any increment.
- R8: A non-indirect command with bit 0 set adds one to the selected column at completion, and 39 wraps to 0. The register's bits 7:6 and all other locations are left unchanged.
- R9: Status bit 6 (alarm) is set at completion when bit 5 or bit 4 is set and an increment was performed.
- R10: For an indirect command, bits 2:0 pick a resource register. Direction 1 copies that resource into location 1; direction 0 copies location 1 into that resource. No pointer changes.
- R11: Status bit 3 holds the most significant bit of location 1 as it stands after completion.
- R12: Status bit 2 equals `vsync` AND NOT `vsync_mask`. Status bits 1:0 read 0.
- R13: If a host write to location 1, 5 or 7 lands on the same edge as the completion update to that location, the host value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| as_n | input | 1 | Address strobe, active low |
| we | input | 1 | 1 = write, 0 = read |
| idx | input | 3 | Location index |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (0 when not read) |
| vsync | input | 1 | Vertical sync level |
| vsync_mask | input | 1 | 1 hides vsync from status bit 2 |

## Verification
Two things can meet on one clock edge: the completion update of a running command and a host write to the same argument location. The bench provokes this by starting an incrementing command and then writing the main column location exactly LAT edges later, the edge on which the increment lands. It judges the result by reading the location back and expecting the host byte rather than the incremented value. The same run writes a data location in the middle of the busy window to confirm that argument access stays open during a command.

// File: rtl/dph_pkg.sv
package dph_pkg;
  localparam int DW = 8;
  localparam logic [3:0] KIND_IND = 4'b1000;

  typedef struct packed {
    logic [3:0] kind;
    logic       dir;
    logic       psel;
    logic       rsv;
    logic       ainc;
  } cmd_t;

  function automatic logic [5:0] col_step(input logic [5:0] c, input logic [5:0] last);
    return (c == last) ? 6'd0 : c + 6'd1;
  endfunction
endpackage

// File: rtl/dph_seq.sv
module dph_seq import dph_pkg::*; #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  cmd_t cmd_in,
  output logic start,
  output logic busy,
  output logic done,
  output cmd_t cmd_q
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt_q;

  assign start = start_req & ~busy;
  assign done  = busy & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      cmd_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CNT_LOAD;
      cmd_q <= cmd_in;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r4_busy_on: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r4_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r5_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy) |=> $stable(cmd_q));
endmodule

// File: rtl/dph_res_bank.sv
module dph_res_bank import dph_pkg::*; #(
  parameter int NRES = 8,
  localparam int RW = $clog2(NRES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] res_q [NRES];

  for (genvar g = 0; g < NRES; g++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        res_q[g] <= '0;
      else if (we && sel == RW'(g))      res_q[g] <= wdata;
    end
  end

  assign rdata = res_q[sel];
endmodule

// File: rtl/dpu_host_regs.sv
module dpu_host_regs import dph_pkg::*; #(
  parameter int COLW     = 6,
  parameter int COL_LAST = 39,
  parameter int LAT      = 4,
  parameter int NRES     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       as_n,
  input  logic       we,
  input  logic [2:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       vsync,
  input  logic       vsync_mask
);
  localparam int RW = $clog2(NRES);
  localparam logic [COLW-1:0] LASTC = COLW'(COL_LAST);

  logic acc, host_wr, start, busy, done;
  cmd_t cmd_q;
  logic [7:0] cmd_raw;
  logic is_ind, lxm_d, lxa_d, inc_d;
  logic lxm_q, lxa_q, alarm_q, msb_q;
  logic [DW-1:0] arg_q [1:7];
  logic [DW-1:0] arg_d [1:7];
  logic [DW-1:0] res_rd, status;

  assign acc     = cs & ~as_n;
  assign host_wr = acc & we;

  dph_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_req(host_wr && idx == 3'd0),
    .cmd_in(cmd_t'(wdata)),
    .start(start), .busy(busy), .done(done), .cmd_q(cmd_q)
  );

  assign cmd_raw = cmd_q;
  assign is_ind  = (cmd_q.kind == KIND_IND);

  dph_res_bank #(.NRES(NRES)) u_res (
    .clk(clk), .rst_n(rst_n),
    .we(done & is_ind & ~cmd_q.dir),
    .sel(cmd_raw[RW-1:0]),
    .wdata(arg_q[1]),
    .rdata(res_rd)
  );

  assign lxm_d = (arg_q[7][COLW-1:0] == LASTC);
  assign lxa_d = (arg_q[5][COLW-1:0] == LASTC);
  assign inc_d = ~is_ind & cmd_q.ainc;

  always_comb begin
    for (int k = 1; k < 8; k++) arg_d[k] = arg_q[k];
    if (done) begin
      if (is_ind && cmd_q.dir)
        arg_d[1] = res_rd;
      else if (inc_d && cmd_q.psel)
        arg_d[5][COLW-1:0] = col_step(arg_q[5][COLW-1:0], LASTC);
      else if (inc_d)
        arg_d[7][COLW-1:0] = col_step(arg_q[7][COLW-1:0], LASTC);
    end
    for (int k = 1; k < 8; k++)
      if (host_wr && idx == 3'(k)) arg_d[k] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k < 8; k++) arg_q[k] <= '0;
    end else begin
      for (int k = 1; k < 8; k++) arg_q[k] <= arg_d[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lxm_q <= 1'b0; lxa_q <= 1'b0; alarm_q <= 1'b0; msb_q <= 1'b0;
    end else if (start) begin
      lxm_q <= 1'b0; lxa_q <= 1'b0; alarm_q <= 1'b0; msb_q <= 1'b0;
    end else if (done) begin
      lxm_q   <= lxm_d;
      lxa_q   <= lxa_d;
      alarm_q <= (lxm_d | lxa_d) & inc_d;
      msb_q   <= arg_d[1][DW-1];
    end
  end

  assign status = {busy, alarm_q, lxm_q, lxa_q, msb_q, vsync & ~vsync_mask, 2'b00};

  always_comb begin
    rdata = '0;
    if (acc && !we) begin
      if (idx == 3'd0) rdata = status;
      for (int k = 1; k < 8; k++)
        if (idx == 3'(k)) rdata = arg_q[k];
    end
  end

  a_r6_clear_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!lxm_q && !lxa_q && !alarm_q && !msb_q));
  a_r7_main_eor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && arg_q[7][COLW-1:0] == LASTC) |=> lxm_q);
  a_r8_wrap_main: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_ind && cmd_q.ainc && !cmd_q.psel && arg_q[7][COLW-1:0] == LASTC
     && !(host_wr && idx == 3'd7)) |=> (arg_q[7][COLW-1:0] == '0));
  a_r9_alarm_needs_eor: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q |-> (lxm_q || lxa_q));
  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> (rdata == '0));
endmodule

// File: tb/dpu_host_regs_tb.sv
`timescale 1ns/1ps
module dpu_host_regs_tb;
  localparam int LAT = 4;
  localparam int NV  = 8;
  // {cmd, r5_in, r7_in, r5_exp, r7_exp, status_exp}
  localparam logic [47:0] VEC [NV] = '{
    48'h21_00_05_00_06_00,
    48'h21_00_27_00_00_60,
    48'h20_00_27_00_27_20,
    48'h25_27_00_00_00_50,
    48'h24_27_00_27_00_10,
    48'h25_E7_12_C0_12_50,
    48'h21_00_90_00_91_00,
    48'h21_27_27_27_00_70
  };

  logic clk = 0, rst_n = 0, cs = 0, as_n = 1, we = 0, vsync = 0, vsync_mask = 0;
  logic [2:0] idx = '0;
  logic [7:0] wdata = '0, rdata, v;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dpu_host_regs #(.LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .as_n(as_n), .we(we), .idx(idx),
    .wdata(wdata), .rdata(rdata), .vsync(vsync), .vsync_mask(vsync_mask)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic a, input logic w,
                       input logic [2:0] i, input logic [7:0] d);
    cs = c; as_n = a; we = w; idx = i; wdata = d;
    @(posedge clk);
    @(negedge clk);
    cs = 0; as_n = 1; we = 0;
  endtask

  task automatic wr(input logic [2:0] i, input logic [7:0] d);
    drive(1'b1, 1'b0, 1'b1, i, d);
  endtask

  task automatic rd(input logic [2:0] i, output logic [7:0] d);
    cs = 1; as_n = 0; we = 0; idx = i;
    #1 d = rdata;
    cs = 0; as_n = 1;
    #0.1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R2: reset values
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), v); check("R2 reset", v, 8'h00);
    end
    // R1: gated writes and quiet read bus
    drive(1'b0, 1'b0, 1'b1, 3'd2, 8'h55);
    drive(1'b1, 1'b1, 1'b1, 3'd2, 8'h66);
    rd(3'd2, v); check("R1 gated write", v, 8'h00);
    wr(3'd2, 8'h3C);
    rd(3'd2, v); check("R2 write", v, 8'h3C);
    cs = 0; as_n = 0; we = 0; idx = 3'd2; #1;
    check("R1 rdata idle", rdata, 8'h00);
    as_n = 1;
    // R7 R8 R9 R3: vector table
    for (int n = 0; n < NV; n++) begin
      wr(3'd5, VEC[n][39:32]);
      wr(3'd7, VEC[n][31:24]);
      wr(3'd0, VEC[n][47:40]);
      idle(LAT);
      rd(3'd5, v); check("R8 aux ptr", v, VEC[n][23:16]);
      rd(3'd7, v); check("R8 main ptr", v, VEC[n][15:8]);
      rd(3'd0, v); check("R7 R9 status", v, VEC[n][7:0]);
    end
    wr(3'd5, 8'h00);
    // R4: busy window
    wr(3'd7, 8'h05);
    wr(3'd0, 8'h21);
    rd(3'd0, v); check("R4 busy set", v, 8'h80);
    idle(LAT - 1);
    rd(3'd0, v); check("R4 busy held", v, 8'h80);
    idle(1);
    rd(3'd0, v); check("R4 busy clear", v, 8'h00);
    rd(3'd7, v); check("R4 result", v, 8'h06);
    // R5: second command while busy ignored
    wr(3'd0, 8'h21);
    wr(3'd0, 8'h21);
    idle(LAT + 3);
    rd(3'd7, v); check("R5 ignored cmd", v, 8'h07);
    rd(3'd0, v); check("R5 idle status", v, 8'h00);
    // R6: flags cleared at start
    wr(3'd7, 8'h27);
    wr(3'd0, 8'h21);
    idle(LAT);
    rd(3'd0, v); check("R6 pre flags", v, 8'h60);
    wr(3'd0, 8'h20);
    rd(3'd0, v); check("R6 cleared", v, 8'h80);
    idle(LAT);
    // R10 R11: indirect transfers
    wr(3'd1, 8'hA5);
    wr(3'd0, 8'h83);
    idle(LAT);
    rd(3'd1, v); check("R10 store keeps R1", v, 8'hA5);
    rd(3'd0, v); check("R11 msb", v, 8'h08);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h8B);
    idle(LAT);
    rd(3'd1, v); check("R10 load", v, 8'hA5);
    rd(3'd7, v); check("R10 no ptr change", v, 8'h00);
    wr(3'd0, 8'h8D);
    idle(LAT);
    rd(3'd1, v); check("R10 other resource", v, 8'h00);
    rd(3'd0, v); check("R11 msb low", v, 8'h00);
    // R12: vsync gating
    vsync = 1; vsync_mask = 0;
    rd(3'd0, v); check("R12 vsync shown", v, 8'h04);
    vsync_mask = 1;
    rd(3'd0, v); check("R12 vsync masked", v, 8'h00);
    vsync = 0; vsync_mask = 0;
    // R13: host write collides with completion update
    wr(3'd7, 8'h05);
    wr(3'd0, 8'h21);
    wr(3'd2, 8'h77);
    idle(LAT - 2);
    wr(3'd7, 8'h30);
    rd(3'd7, v); check("R13 host wins", v, 8'h30);
    rd(3'd2, v); check("R2 write during busy", v, 8'h77);
    rd(3'd0, v); check("R13 status", v, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule